// File: doc/BRIEF.md
# Prioritized Interrupt Flag Controller

This block gathers interrupt requests from three groups of eight sources each: a timer group, an external-edge group and a serial group. Each source is set to be level-sensitive (active low) or edge-sensitive with a chosen polarity. A source event latches a flag bit. A flag is cleared only when software writes a one to it, and that write acts for one cycle only. Each group has an enable register beside its flag register. Both registers are reached over a small register bus with combinational read data.

Of the flags that are both latched and enabled, the block picks the one with the highest priority. The serial group ranks above the edge group, which ranks above the timer group. Within a group, a higher bit number wins. The block drives a 5-bit vector code for the winner and raises the processor interrupt request unless a global mask input holds it off. A run indicator drops after a wait-for-interrupt event and comes back high when any enabled flag is pending.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset all flag and enable registers read 0, `irq_o` is 0, `irq_vec_o` is 0 and `run_o` is 1.
- R2: A source whose `src_mode_i` bit is 0 is level-sensitive. Its flag reads 1 on the third rising clock edge after its request input goes low. While the input stays low, the flag is set again every cycle, so a write-1 clear does not remove it. After the input returns high, the flag stays latched until it is cleared.
- R3: A source whose `src_mode_i` bit is 1 is edge-sensitive. Its flag is set by a transition of the synchronized input to the polarity in `src_pol_i`: 1 means a rising edge, 0 means a falling edge. The transition to the other level does not set it, and holding the input at the active level does not set it again after a clear.
- R4: A register write with a 1 in a bit of a flag register clears that flag in the following cycle. A 0 bit leaves the flag unchanged. If a source sets a flag in the same cycle as a clear, the set wins.
- R5: Register addresses: 0 timer flags, 1 timer enables, 2 edge flags, 3 edge enables, 4 serial flags, 5 serial enables. A write to an enable address loads the enable register. `bus_rdata_o` shows the addressed register in the same cycle. Addresses 6 and 7 read 0, and writes to them change nothing.
- R6: `irq_o` is 1 exactly when some flag and its enable bit in the same group are both 1 and `irq_mask_i` is 0. When `irq_mask_i` is 1, `irq_o` is 0.
- R7: `irq_vec_o` is {group[1:0], bit[2:0]}, with group 0 timer, 1 edge and 2 serial. It names the enabled pending flag in the highest group and, within that group, at the highest bit. It is 0 when `irq_o` is 0.
- R8: A `wai_i` pulse while `emu_mode_i` is 0 and no enabled flag is pending drives `run_o` low on the next cycle. A `wai_i` pulse while `emu_mode_i` is 1 is ignored. When an enabled flag is pending, `run_o` is 1 on the next cycle, whatever the state of `irq_mask_i`.
- R9: A latched, enabled flag keeps `irq_o` and its vector asserted for as long as it is not cleared, even after its source goes inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req_i | input | 24 | Source request lines: timer [7:0], edge [15:8], serial [23:16] |
| src_mode_i | input | 24 | Per source: 0 level-sensitive, 1 edge-sensitive |
| src_pol_i | input | 24 | Per edge source: 1 rising, 0 falling |
| bus_addr_i | input | 3 | Register address |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data of the addressed register |
| irq_mask_i | input | 1 | Global interrupt mask, 1 blocks `irq_o` |
| wai_i | input | 1 | Wait-for-interrupt event pulse |
| emu_mode_i | input | 1 | 1 selects the mode in which `wai_i` is ignored |
| irq_o | output | 1 | Processor interrupt request |
| irq_vec_o | output | 5 | Winning source code {group, bit} |
| run_o | output | 1 | Run indicator |

## Verification
The flag assertions assume that the request inputs are idle at the reset value of the synchronizers (high) and that `bus_wr_i` is low during reset. If they are not, a spurious edge would set a flag at release. The bench therefore holds every request line high while idle, with falling-edge polarity as the default. It changes a mode or polarity bit only while its input is high. Each scenario returns every line to high and clears the flags before it ends, so no scenario leaves an edge or a latched flag for the next one.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Source sensitivity as selected per bit by src_mode_i
  typedef enum logic {
    SENSE_LEVEL = 1'b0,
    SENSE_EDGE  = 1'b1
  } sense_e;

  // Group numbering, also the upper field of the vector code
  typedef enum logic [1:0] {
    GRP_TIMER  = 2'd0,
    GRP_EDGE   = 2'd1,
    GRP_SERIAL = 2'd2
  } grp_e;

  // Index width of a field that must count n items (at least one bit)
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Register map: each group owns a flag/enable pair, flag at the even slot
  function automatic int flag_addr(input int grp);
    return grp * 2;
  endfunction

  function automatic int en_addr(input int grp);
    return grp * 2 + 1;
  endfunction

endpackage

// File: rtl/irq_src_group.sv
module irq_src_group #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req_i,
  input  logic [W-1:0] mode_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] clr_i,
  input  logic         en_we_i,
  input  logic [W-1:0] en_wdata_i,
  output logic [W-1:0] flag_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] set_o,
  output logic [W-1:0] pend_o
);
  import irq_pkg::*;

  logic [W-1:0] sync1_q, sync2_q, prev_q;
  logic [W-1:0] flag_q, en_q;
  logic [W-1:0] set_w, flag_d;

  // Per-bit source event: level sources fire while low, edge sources on a
  // change into the chosen polarity
  function automatic logic [W-1:0] detect(input logic [W-1:0] cur,
                                          input logic [W-1:0] prev,
                                          input logic [W-1:0] mode,
                                          input logic [W-1:0] pol);
    logic [W-1:0] r;
    for (int b = 0; b < W; b++) begin
      if (sense_e'(mode[b]) == SENSE_EDGE)
        r[b] = (cur[b] == pol[b]) && (prev[b] != pol[b]);
      else
        r[b] = ~cur[b];
    end
    return r;
  endfunction

  // Set dominates a same-cycle clear
  function automatic logic [W-1:0] next_flag(input logic [W-1:0] flag,
                                             input logic [W-1:0] set,
                                             input logic [W-1:0] clr);
    return set | (flag & ~clr);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '1;
      sync2_q <= '1;
      prev_q  <= '1;
    end else begin
      sync1_q <= req_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign set_w  = detect(sync2_q, prev_q, mode_i, pol_i);
  assign flag_d = next_flag(flag_q, set_w, clr_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= flag_d;
      if (en_we_i) en_q <= en_wdata_i;
    end
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign set_o  = set_w;
  assign pend_o = flag_q & en_q;

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int GROUPS  = 3,
  parameter int GROUP_W = 8
) (
  input  logic [GROUPS*GROUP_W-1:0] pend_i,
  output logic                      any_o,
  output logic [irq_pkg::idx_w(GROUPS)+irq_pkg::idx_w(GROUP_W)-1:0] vec_o
);
  localparam int N  = GROUPS * GROUP_W;
  localparam int GW = irq_pkg::idx_w(GROUPS);
  localparam int BW = irq_pkg::idx_w(GROUP_W);

  // Flat index of the highest set bit; higher group sits at higher index
  function automatic int top_idx(input logic [N-1:0] v);
    int r;
    r = 0;
    for (int i = 0; i < N; i++)
      if (v[i]) r = i;
    return r;
  endfunction

  int top_w;

  assign any_o = |pend_i;
  assign top_w = top_idx(pend_i);
  assign vec_o = any_o ? {GW'(top_w / GROUP_W), BW'(top_w % GROUP_W)} : '0;

endmodule

// File: rtl/irq_run_ctl.sv
module irq_run_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wai_i,
  input  logic emu_i,
  input  logic wake_i,
  output logic run_o
);
  logic run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              run_q <= 1'b1;
    else if (wake_i)         run_q <= 1'b1;
    else if (wai_i && !emu_i) run_q <= 1'b0;
  end

  assign run_o = run_q;

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int GROUPS  = 3,
  parameter int GROUP_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [GROUPS*GROUP_W-1:0] src_req_i,
  input  logic [GROUPS*GROUP_W-1:0] src_mode_i,
  input  logic [GROUPS*GROUP_W-1:0] src_pol_i,
  input  logic [irq_pkg::idx_w(2*GROUPS)-1:0] bus_addr_i,
  input  logic                      bus_wr_i,
  input  logic [GROUP_W-1:0]        bus_wdata_i,
  output logic [GROUP_W-1:0]        bus_rdata_o,
  input  logic                      irq_mask_i,
  input  logic                      wai_i,
  input  logic                      emu_mode_i,
  output logic                      irq_o,
  output logic [irq_pkg::idx_w(GROUPS)+irq_pkg::idx_w(GROUP_W)-1:0] irq_vec_o,
  output logic                      run_o
);
  localparam int N      = GROUPS * GROUP_W;
  localparam int ADDR_W = irq_pkg::idx_w(2 * GROUPS);
  localparam int VEC_W  = irq_pkg::idx_w(GROUPS) + irq_pkg::idx_w(GROUP_W);

  // Named internal events, also observed by the bound checker
  logic [N-1:0]     flag_all, en_all, set_all, clr_all, pend_all;
  logic             pend_any;
  logic [VEC_W-1:0] enc_vec;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(irq_pkg::flag_addr(g));
    localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(irq_pkg::en_addr(g));

    logic wr_flag, wr_en;
    assign wr_flag = bus_wr_i && (bus_addr_i == FLAG_A);
    assign wr_en   = bus_wr_i && (bus_addr_i == EN_A);
    assign clr_all[g*GROUP_W +: GROUP_W] = wr_flag ? bus_wdata_i : '0;

    irq_src_group #(.W(GROUP_W)) u_grp (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (src_req_i [g*GROUP_W +: GROUP_W]),
      .mode_i     (src_mode_i[g*GROUP_W +: GROUP_W]),
      .pol_i      (src_pol_i [g*GROUP_W +: GROUP_W]),
      .clr_i      (clr_all   [g*GROUP_W +: GROUP_W]),
      .en_we_i    (wr_en),
      .en_wdata_i (bus_wdata_i),
      .flag_o     (flag_all  [g*GROUP_W +: GROUP_W]),
      .en_o       (en_all    [g*GROUP_W +: GROUP_W]),
      .set_o      (set_all   [g*GROUP_W +: GROUP_W]),
      .pend_o     (pend_all  [g*GROUP_W +: GROUP_W])
    );
  end

  // Combinational register read; unmapped addresses return zero
  always_comb begin
    bus_rdata_o = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (bus_addr_i == ADDR_W'(irq_pkg::flag_addr(g)))
        bus_rdata_o = flag_all[g*GROUP_W +: GROUP_W];
      if (bus_addr_i == ADDR_W'(irq_pkg::en_addr(g)))
        bus_rdata_o = en_all[g*GROUP_W +: GROUP_W];
    end
  end

  irq_prio_enc #(.GROUPS(GROUPS), .GROUP_W(GROUP_W)) u_enc (
    .pend_i (pend_all),
    .any_o  (pend_any),
    .vec_o  (enc_vec)
  );

  assign irq_o     = pend_any & ~irq_mask_i;
  assign irq_vec_o = irq_o ? enc_vec : '0;

  irq_run_ctl u_run (
    .clk    (clk),
    .rst_n  (rst_n),
    .wai_i  (wai_i),
    .emu_i  (emu_mode_i),
    .wake_i (pend_any),
    .run_o  (run_o)
  );

endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk #(
  parameter int GROUPS  = 3,
  parameter int GROUP_W = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      irq_mask_i,
  input logic                      wai_i,
  input logic                      emu_mode_i,
  input logic                      irq_o,
  input logic [irq_pkg::idx_w(GROUPS)+irq_pkg::idx_w(GROUP_W)-1:0] irq_vec_o,
  input logic                      run_o,
  input logic [GROUPS*GROUP_W-1:0] flag_all,
  input logic [GROUPS*GROUP_W-1:0] clr_all,
  input logic [GROUPS*GROUP_W-1:0] set_all,
  input logic [GROUPS*GROUP_W-1:0] pend_all
);
  localparam int N     = GROUPS * GROUP_W;
  localparam int BW    = irq_pkg::idx_w(GROUP_W);
  localparam int VEC_W = irq_pkg::idx_w(GROUPS) + BW;

  logic [31:0] idx_w;
  assign idx_w = 32'(irq_vec_o[VEC_W-1:BW]) * GROUP_W + 32'(irq_vec_o[BW-1:0]);

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((|pend_all) && !irq_mask_i)); // R6

  AST_VEC_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> pend_all[idx_w]); // R7

  AST_VEC_IS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((pend_all >> idx_w) == N'(1))); // R7

  AST_VEC_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (irq_vec_o == '0)); // R7

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flag_all) & ~$past(clr_all) & ~flag_all) == '0)); // R9

  AST_FLAG_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_all & ~$past(flag_all) & ~$past(set_all)) == '0)); // R3

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(clr_all) & ~$past(set_all) & flag_all) == '0)); // R4

  AST_RUN_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_o && (|pend_all)) |=> run_o); // R8

  AST_RUN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wai_i && !emu_mode_i && !(|pend_all)) |=> !run_o); // R8

  AST_RUN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && !(wai_i && !emu_mode_i)) |=> run_o); // R8

endmodule

bind irq_prio_ctrl irq_prio_chk #(.GROUPS(GROUPS), .GROUP_W(GROUP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_mask_i (irq_mask_i),
  .wai_i      (wai_i),
  .emu_mode_i (emu_mode_i),
  .irq_o      (irq_o),
  .irq_vec_o  (irq_vec_o),
  .run_o      (run_o),
  .flag_all   (flag_all),
  .clr_all    (clr_all),
  .set_all    (set_all),
  .pend_all   (pend_all)
);

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] req  = '1;
  logic [23:0] mode = '1;
  logic [23:0] pol  = '0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        mask = 1'b0, wai = 1'b0, emu = 1'b0;
  logic        irq, run;
  logic [4:0]  vec;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_req_i(req), .src_mode_i(mode), .src_pol_i(pol),
    .bus_addr_i(bus_addr), .bus_wr_i(bus_wr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .irq_mask_i(mask), .wai_i(wai), .emu_mode_i(emu),
    .irq_o(irq), .irq_vec_o(vec), .run_o(run)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    bus_addr = 3'(a); bus_wdata = d; bus_wr = 1'b1;
    tick(1);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input int a, input logic [7:0] exp);
    bus_addr = 3'(a);
    #1;
    chk(tag, 32'(bus_rdata), 32'(exp));
  endtask

  // Expected winner: scan serial, then edge, then timer, each from bit 7 down
  function automatic logic [4:0] exp_vec(input logic [23:0] p);
    for (int g = 2; g >= 0; g--)
      for (int b = 7; b >= 0; b--)
        if (p[g*8+b]) return {2'(g), 3'(b)};
    return 5'd0;
  endfunction

  task automatic clear_all();
    req = '1;
    tick(4);
    wr(0, 8'hFF); wr(2, 8'hFF); wr(4, 8'hFF);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 8; a++) rd_chk("R1 reg after reset", a, 8'h00);
    chk("R1 irq_o after reset", 32'(irq), 0);
    chk("R1 vec after reset", 32'(vec), 0);
    chk("R1 run_o after reset", 32'(run), 1);
  endtask

  task automatic t_regmap();
    wr(1, 8'hA5); wr(3, 8'h3C); wr(5, 8'h81);
    rd_chk("R5 timer enable", 1, 8'hA5);
    rd_chk("R5 edge enable", 3, 8'h3C);
    rd_chk("R5 serial enable", 5, 8'h81);
    wr(6, 8'hFF); wr(7, 8'hFF);
    rd_chk("R5 addr6 reads 0", 6, 8'h00);
    rd_chk("R5 addr7 reads 0", 7, 8'h00);
    rd_chk("R5 timer enable after unmapped write", 1, 8'hA5);
    rd_chk("R5 serial enable after unmapped write", 5, 8'h81);
    wr(0, 8'hFF);
    rd_chk("R4 writing flags never sets them", 0, 8'h00);
    chk("R6 no irq with empty flags", 32'(irq), 0);
    wr(1, 8'h00); wr(3, 8'h00); wr(5, 8'h00);
  endtask

  task automatic t_level();
    mode[2] = 1'b0;
    wr(1, 8'h04);
    req[2] = 1'b0;
    tick(2);
    rd_chk("R2 flag not yet set at edge 2", 0, 8'h00);
    tick(1);
    rd_chk("R2 flag set at edge 3", 0, 8'h04);
    chk("R6 irq from level source", 32'(irq), 1);
    chk("R7 vec timer bit 2", 32'(vec), 32'd2);
    wr(0, 8'h04);
    rd_chk("R2 clear while low does not hold", 0, 8'h04);
    req[2] = 1'b1;
    tick(6);
    rd_chk("R2 flag latched after release", 0, 8'h04);
    chk("R9 irq persists uncleared", 32'(irq), 1);
    wr(0, 8'h04);
    rd_chk("R4 clear after release", 0, 8'h00);
    chk("R6 irq drops after clear", 32'(irq), 0);
    mode[2] = 1'b1;
    wr(1, 8'h00);
  endtask

  task automatic t_edge();
    req[5] = 1'b0;
    tick(2);
    rd_chk("R3 falling edge not yet", 0, 8'h00);
    tick(1);
    rd_chk("R3 falling edge sets", 0, 8'h20);
    wr(0, 8'h20);
    tick(3);
    rd_chk("R3 held low does not reset flag", 0, 8'h00);
    req[5] = 1'b1;
    tick(4);
    rd_chk("R3 rising ignored with falling polarity", 0, 8'h00);
    pol[5] = 1'b1;
    tick(2);
    req[5] = 1'b0;
    tick(4);
    rd_chk("R3 falling ignored with rising polarity", 0, 8'h00);
    req[5] = 1'b1;
    tick(3);
    rd_chk("R3 rising edge sets", 0, 8'h20);
    wr(0, 8'h20);
    rd_chk("R4 rising flag cleared", 0, 8'h00);
    pol[5] = 1'b0;
    tick(2);
  endtask

  task automatic t_clear();
    req[1] = 1'b0; req[6] = 1'b0;
    tick(3);
    rd_chk("R3 two flags set", 0, 8'h42);
    wr(0, 8'h00);
    rd_chk("R4 write 0 keeps flags", 0, 8'h42);
    wr(0, 8'h02);
    rd_chk("R4 write 1 clears one bit", 0, 8'h40);
    clear_all();
    rd_chk("R4 all cleared", 0, 8'h00);
    req[3] = 1'b0;
    tick(2);
    bus_addr = 3'd0; bus_wdata = 8'h08; bus_wr = 1'b1;
    tick(1);
    bus_wr = 1'b0;
    rd_chk("R4 set wins over same-cycle clear", 0, 8'h08);
    wr(0, 8'h08);
    rd_chk("R4 later clear works", 0, 8'h00);
    clear_all();
  endtask

  task automatic t_prio();
    logic [23:0] p;
    wr(1, 8'hFF); wr(3, 8'hFF); wr(5, 8'hFF);
    p = 24'h000802;
    req = ~p; tick(3);
    chk("R6 irq with enabled flags", 32'(irq), 1);
    chk("R7 edge3 beats timer1", 32'(vec), 32'(exp_vec(p)));
    chk("R7 edge3 code", 32'(vec), 32'd11);
    req = '1; tick(10);
    chk("R9 vector persists", 32'(vec), 32'd11);
    wr(2, 8'h08);
    chk("R7 timer1 after edge cleared", 32'(vec), 32'd1);
    clear_all();
    p = 24'h000108;
    req = ~p; tick(3);
    chk("R7 edge0 beats timer3", 32'(vec), 32'd8);
    mask = 1'b1; #1;
    chk("R6 mask blocks irq", 32'(irq), 0);
    chk("R7 vec 0 when masked", 32'(vec), 0);
    mask = 1'b0; #1;
    chk("R6 irq back after unmask", 32'(irq), 1);
    clear_all();
    p = 24'h018080;
    req = ~p; tick(3);
    chk("R7 serial0 beats edge7", 32'(vec), 32'd16);
    wr(3, 8'h00); wr(5, 8'h00);
    chk("R7 only timer enabled", 32'(vec), 32'd7);
    wr(1, 8'h00);
    chk("R6 no irq with enables off", 32'(irq), 0);
    chk("R7 vec 0 with enables off", 32'(vec), 0);
    clear_all();
  endtask

  task automatic t_run();
    emu = 1'b1; wai = 1'b1; tick(1); wai = 1'b0;
    chk("R8 wai ignored in emulation mode", 32'(run), 1);
    emu = 1'b0; wai = 1'b1; tick(1); wai = 1'b0;
    chk("R8 run low after wai", 32'(run), 0);
    tick(3);
    chk("R8 run stays low", 32'(run), 0);
    mask = 1'b1;
    wr(1, 8'h01);
    req[0] = 1'b0;
    tick(3);
    chk("R8 run low before wake edge", 32'(run), 0);
    tick(1);
    chk("R8 run high after enabled flag", 32'(run), 1);
    chk("R6 masked irq stays low", 32'(irq), 0);
    wai = 1'b1; tick(1); wai = 1'b0;
    chk("R8 wai with pending keeps run", 32'(run), 1);
    mask = 1'b0;
    clear_all();
    wr(1, 8'h00);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_level();
    t_edge();
    t_clear();
    t_prio();
    t_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule